// File: doc/BRIEF.md
# Coded Frame Builder with Scrambler

This block produces the transmit byte stream for a differential binary PSK link. It holds in an idle state until the upstream FIFO reports that it is at least half full. It then emits frames back to back. Each frame is a fixed 8-byte synchronisation pattern followed by two coded words. Each coded word is 239 payload bytes taken from the FIFO and then 16 check bytes supplied by an external block coder.

Every byte after the synchronisation pattern is XORed with a cyclic 8-byte scrambling mask. The mask restarts at its first byte with each new frame. The whole stream, the synchronisation pattern included, then passes through a bit-serial differential encoder. The encoder processes bits most significant first and keeps its state across bytes, frames and idle gaps. Each encoded byte appears one clock after its slot, marked by a valid strobe. A frame-start pulse marks the first byte of each frame.

The sequencer has four states:
- `ST_IDLE`, waiting for the fill level.
- `ST_PRE`, emitting the synchronisation pattern.
- `ST_DATA`, reading payload.
- `ST_CHECK`, taking check bytes.

Its transitions are:
- IDLE→PRE when the level reaches the start threshold.
- PRE→DATA after the 8th pattern byte.
- DATA→CHECK after the 239th payload byte.
- CHECK→DATA after the 16th check byte of the first word.
- CHECK→PRE, after the last check byte of the second word, if the level is still at or above the threshold.
- CHECK→IDLE, after that same byte, otherwise.

Top module: `fb_frame_builder`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid`, `frame_start`, `fifo_rd` and `parity_slot` are 0.
- R2: From idle, no frame starts while `fifo_level` is below START_LEVEL (default 512, half of a 1024-entry FIFO); a level of exactly START_LEVEL starts a frame on the next cycle.
- R3: A frame occupies 518 consecutive slot cycles: 8 pattern slots, 239 data slots, 16 check slots, 239 data slots, 16 check slots; `fifo_rd` is 1 in exactly the data slots and `parity_slot` in exactly the check slots, never both.
- R4: Pattern slot i (0..7) carries byte i of the 64-bit PREAMBLE parameter, byte 0 being bits 63:56, and is not scrambled.
- R5: Coded byte n of a frame (n = 0..509, counted across data and check slots) is XORed with byte (n mod 8) of the 64-bit SCR_MASK parameter, byte 0 being bits 63:56.
- R6: Each byte b is encoded most significant bit first as d = d_prev XOR b[i], each result bit forming the output bit at the same position; d starts at 0 after reset, and it is held across idle gaps and frames.
- R7: `out_valid` is 1 exactly one cycle after each slot, `out_byte` is that slot's encoded byte, and `frame_start` is 1 only together with the first pattern byte of each frame.
- R8: At the last check slot of a frame, a level at or above START_LEVEL starts the next frame's pattern on the next cycle with no gap; otherwise the block returns to idle.
- R9: During a check slot, the byte on `parity_in` in that cycle is the one that is scrambled and encoded; during a data slot, `fifo_rdata` in that cycle is used (show-ahead FIFO).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | 11 | Current FIFO fill level |
| fifo_rdata | input | 8 | Show-ahead FIFO head byte |
| fifo_rd | output | 1 | Pops the FIFO head this cycle |
| parity_in | input | 8 | Check byte from the external coder |
| parity_slot | output | 1 | This cycle is a check-byte slot |
| out_byte | output | 8 | Differentially encoded output byte |
| out_valid | output | 1 | `out_byte` holds a frame byte |
| frame_start | output | 1 | First byte of a frame |

## Verification
On every cycle, the assertions check several local rules:
- every rise of the valid strobe coincides with a frame start;
- a frame start never appears without valid;
- FIFO reads and check slots are mutually exclusive;
- each data run begins at count zero;
- the encoder state holds while idle;
- the mask index restarts at each frame.

Only the bench scenarios can show that the byte values are correct: the pattern bytes, the mask order, the differential chain across bytes and gaps, and the 518-slot schedule. The bench compares these on every clock against a behavioural model. The same applies to the threshold boundary and to the choice between back-to-back frames and a return to idle.

// File: rtl/fb_pkg.sv
package fb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_CHECK
    } fb_state_e;
endpackage

// File: rtl/fb_sequencer.sv
module fb_sequencer
    import fb_pkg::*;
#(
    parameter int PRE_LEN     = 8,
    parameter int DATA_LEN    = 239,
    parameter int CHECK_LEN   = 16,
    parameter int WORDS       = 2,
    parameter int START_LEVEL = 512,
    parameter int LVL_W       = 11,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    output fb_state_e        state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             first_coded_o
);
    localparam int WORD_W = $clog2(WORDS + 1);

    fb_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] word_q, word_d;
    logic              level_go;

    assign level_go = (level_i >= LVL_W'(START_LEVEL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        word_d  = word_q;
        unique case (state_q)
            ST_IDLE: begin
                if (level_go) begin
                    state_d = ST_PRE;
                    cnt_d   = '0;
                end
            end
            ST_PRE: begin
                if (cnt_q == CNT_W'(PRE_LEN - 1)) begin
                    state_d = ST_DATA;
                    cnt_d   = '0;
                    word_d  = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DATA: begin
                if (cnt_q == CNT_W'(DATA_LEN - 1)) begin
                    state_d = ST_CHECK;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_CHECK: begin
                if (cnt_q == CNT_W'(CHECK_LEN - 1)) begin
                    cnt_d = '0;
                    if (word_q == WORD_W'(WORDS - 1)) begin
                        state_d = level_go ? ST_PRE : ST_IDLE;
                    end else begin
                        state_d = ST_DATA;
                        word_d  = word_q + 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o       = state_q;
        cnt_o         = cnt_q;
        first_coded_o = (state_q == ST_DATA) && (cnt_q == '0) && (word_q == '0);
    end

    // R2: idle persists while the level is below threshold
    a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !level_go) |=> (state_q == ST_IDLE));

    // R3: every data run begins at slot count zero
    a_r3_data_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) != ST_DATA) |-> (cnt_q == '0));
endmodule

// File: rtl/fb_scrambler.sv
module fb_scrambler
    import fb_pkg::*;
#(
    parameter int          SCR_LEN  = 8,
    parameter logic [63:0] SCR_MASK = 64'h9E37_79B9_7F4A_7C15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coded_i,
    input  logic              first_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int IDX_W = $clog2(SCR_LEN);

    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  cur;
    logic [BYTE_W-1:0] mask_byte;

    assign cur       = first_i ? '0 : idx_q;
    assign mask_byte = SCR_MASK[(SCR_LEN - 1 - int'(cur)) * BYTE_W +: BYTE_W];
    assign byte_o    = coded_i ? (byte_i ^ mask_byte) : byte_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (coded_i) begin
            if (int'(cur) == SCR_LEN - 1) idx_q <= '0;
            else                          idx_q <= cur + 1'b1;
        end
    end

    // R5: the mask sequence restarts at each frame's first coded byte
    a_r5_restart_next: assert property (@(posedge clk) disable iff (!rst_n)
        (coded_i && first_i) |=> (idx_q == IDX_W'(1)));
endmodule

// File: rtl/fb_diff_enc.sv
module fb_diff_enc
    import fb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    logic              d_q;
    logic [BYTE_W:0]   carry;
    logic [BYTE_W-1:0] enc;

    assign carry[BYTE_W] = d_q;

    for (genvar i = BYTE_W - 1; i >= 0; i--) begin : g_bit
        assign carry[i] = carry[i+1] ^ in_byte[i];
        assign enc[i]   = carry[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q       <= 1'b0;
            out_byte  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_byte <= enc;
                d_q      <= carry[0];
            end
        end
    end

    // R6: the encoder state is held while no byte is presented
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(d_q));
endmodule

// File: rtl/fb_frame_builder.sv
module fb_frame_builder
    import fb_pkg::*;
#(
    parameter int          PRE_LEN     = 8,
    parameter int          DATA_LEN    = 239,
    parameter int          CHECK_LEN   = 16,
    parameter int          WORDS       = 2,
    parameter int          FIFO_DEPTH  = 1024,
    parameter int          START_LEVEL = FIFO_DEPTH / 2,
    parameter int          SCR_LEN     = 8,
    parameter logic [63:0] PREAMBLE    = 64'hF3A0_5C6E_9B21_D487,
    parameter logic [63:0] SCR_MASK    = 64'h9E37_79B9_7F4A_7C15,
    localparam int         LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [7:0]       fifo_rdata,
    output logic             fifo_rd,
    input  logic [7:0]       parity_in,
    output logic             parity_slot,
    output logic [7:0]       out_byte,
    output logic             out_valid,
    output logic             frame_start
);
    localparam int CNT_W = $clog2(PRE_LEN + DATA_LEN + CHECK_LEN + 1);

    fb_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic              first_coded;
    logic              in_pre, coded, slot_valid;
    logic [BYTE_W-1:0] raw_byte, scr_byte;

    fb_sequencer #(
        .PRE_LEN(PRE_LEN), .DATA_LEN(DATA_LEN), .CHECK_LEN(CHECK_LEN),
        .WORDS(WORDS), .START_LEVEL(START_LEVEL), .LVL_W(LVL_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .level_i(fifo_level),
        .state_o(state), .cnt_o(cnt), .first_coded_o(first_coded)
    );

    always_comb begin
        in_pre      = (state == ST_PRE);
        fifo_rd     = (state == ST_DATA);
        parity_slot = (state == ST_CHECK);
        coded       = fifo_rd || parity_slot;
        slot_valid  = in_pre || coded;
        unique case (state)
            ST_PRE:   raw_byte = PREAMBLE[(PRE_LEN - 1 - int'(cnt)) * BYTE_W +: BYTE_W];
            ST_DATA:  raw_byte = fifo_rdata;
            ST_CHECK: raw_byte = parity_in;
            default:  raw_byte = '0;
        endcase
    end

    fb_scrambler #(.SCR_LEN(SCR_LEN), .SCR_MASK(SCR_MASK)) u_scr (
        .clk(clk), .rst_n(rst_n), .coded_i(coded), .first_i(first_coded),
        .byte_i(raw_byte), .byte_o(scr_byte)
    );

    fb_diff_enc u_denc (
        .clk(clk), .rst_n(rst_n), .in_valid(slot_valid), .in_byte(scr_byte),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) frame_start <= 1'b0;
        else        frame_start <= in_pre && (cnt == '0);
    end

    // R7: a burst of valid bytes always opens with a frame start
    a_r7_rise_is_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> frame_start);

    // R7: frame start only accompanies a valid byte
    a_r7_fs_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> out_valid);

    // R3: FIFO pops and check slots never coincide
    a_r3_rd_excl_pslot: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_rd && parity_slot));
endmodule

// File: tb/fb_frame_builder_tb_top.sv
module fb_frame_builder_tb_top;
    localparam int          START = 512;
    localparam logic [63:0] PRE   = 64'hF3A0_5C6E_9B21_D487;
    localparam logic [63:0] MASK  = 64'h9E37_79B9_7F4A_7C15;
    localparam int          FLEN  = 518;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] fifo_level = '0;
    logic [7:0]  fifo_rdata = '0;
    logic [7:0]  parity_in = '0;
    logic        fifo_rd, parity_slot, out_valid, frame_start;
    logic [7:0]  out_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fb_frame_builder dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_rdata(fifo_rdata),
        .fifo_rd(fifo_rd), .parity_in(parity_in), .parity_slot(parity_slot),
        .out_byte(out_byte), .out_valid(out_valid), .frame_start(frame_start)
    );

    // behavioural reference state
    bit   m_run = 0;
    int   m_pos = 0;
    bit   m_d = 0;
    int   m_fifo_ctr = 0;
    bit   e_valid = 0, e_fs = 0;
    logic [7:0] e_byte = '0;
    int   fs_seen = 0, rd_seen = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] fifo_byte(input int n);
        return 8'((n * 7 + 3) & 255);
    endfunction

    task automatic step(input logic [10:0] lvl);
        bit   is_pre, is_data, is_chk;
        int   k, j, cidx;
        logic [7:0] raw, scr, enc;
        bit   d;
        @(negedge clk);
        // registered outputs reflect the previous slot (R6, R7)
        chk("R7", "out_valid", int'(out_valid), int'(e_valid));
        chk("R7", "frame_start", int'(frame_start), int'(e_fs));
        if (e_valid) chk("R6", "out_byte", int'(out_byte), int'(e_byte));
        if (frame_start) fs_seen++;
        // slot classification of this cycle from the model
        is_pre = 0; is_data = 0; is_chk = 0; k = 0; cidx = 0;
        if (m_run) begin
            if (m_pos < 8) is_pre = 1;
            else begin
                k = m_pos - 8;
                j = k % 255;
                if (j < 239) is_data = 1;
                else begin is_chk = 1; cidx = j - 239; end
            end
        end
        fifo_level = lvl;
        fifo_rdata = fifo_byte(m_fifo_ctr);
        parity_in  = 8'hA5 ^ 8'(cidx * 17 + (k / 255));
        #1;
        chk("R3", "fifo_rd", int'(fifo_rd), int'(is_data));
        chk("R3", "parity_slot", int'(parity_slot), int'(is_chk));
        if (fifo_rd) rd_seen++;
        // expected output for next cycle (R4, R5, R9)
        e_valid = m_run;
        e_fs    = m_run && (m_pos == 0);
        if (m_run) begin
            if (is_pre) raw = PRE[(7 - m_pos) * 8 +: 8];
            else if (is_data) raw = fifo_rdata;
            else raw = parity_in;
            scr = is_pre ? raw : (raw ^ MASK[(7 - (k % 8)) * 8 +: 8]);
            d = m_d;
            for (int b = 7; b >= 0; b--) begin
                d = d ^ scr[b];
                enc[b] = d;
            end
            m_d = d;
            e_byte = enc;
            if (is_data) m_fifo_ctr++;
            m_pos++;
            if (m_pos == FLEN) begin
                m_pos = 0;
                m_run = (lvl >= 11'(START)); // R8
            end
        end else if (lvl >= 11'(START)) begin
            m_run = 1; // R2
            m_pos = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "frame_start in reset", int'(frame_start), 0);
        chk("R1", "fifo_rd in reset", int'(fifo_rd), 0);
        chk("R1", "parity_slot in reset", int'(parity_slot), 0);
        rst_n = 1'b1;
        for (int t = 0; t < 1700; t++) begin
            logic [10:0] lvl;
            if (t < 20)        lvl = 11'd0;
            else if (t < 40)   lvl = 11'(START - 1); // R2 boundary below
            else if (t < 1000) lvl = 11'(START);     // R2 exact threshold
            else if (t < 1100) lvl = 11'd3;          // R8 return to idle
            else if (t < 1400) lvl = 11'd1024;
            else               lvl = 11'd0;
            step(lvl);
        end
        chk("R8", "frames started", fs_seen, 3);
        chk("R3", "fifo pops", rd_seen, 3 * 478);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule